// File: doc/BRIEF.md
# Register Move and Immediate Load Unit

This unit holds the 32-entry, 16-bit register file of a small DSP core and carries out three instruction forms on it. A move copies one register into another. A long immediate load takes a 16-bit constant from the instruction word that follows it. A short immediate load places a sign-extended 8-bit constant into one of the upper eight registers. Two of the registers are 40-bit accumulators, and each one is split over three entries: an 8-bit high part, a 16-bit middle part and a 16-bit low part. The unit treats these entries specially on both reads and writes.

A mode input selects 40-bit behaviour. With the mode on, reading an accumulator's middle entry as a move source gives a saturated 16-bit view of the whole accumulator. Writing an accumulator's middle entry spreads the written value across the whole accumulator. With the mode off, the middle entry behaves like any other register. The long load waits in a second state until the following word arrives on a valid/ready handshake. Other execution units read the registers through a combinational read port.

Top module: `mrm_move_load`

## Requirements
- R1: While rst_n is low and on the cycle after it, every register reads zero and busy and imm_ready are low.
- R2: A word with bits 15:10 = 000111 is a move. It copies register bits 4:0 into register bits 9:5 at the clock edge where instr_valid is sampled high, unless the source is 0x1E or 0x1F.
- R3: With mode40 high, a move whose source is 0x1E or 0x1F (middle parts of accumulators 0 and 1) checks the high part. If bits 7:0 of the high part (0x10 or 0x11) are not all equal to bit 15 of the middle part, the move delivers 0x8000 when high bit 7 is 1 and 0x7FFF when it is 0. Otherwise it delivers the middle part.
- R4: With mode40 low, a move from 0x1E or 0x1F delivers the raw middle part.
- R5: A word with bits 15:5 = 00000000100 is a long load to register bits 4:0. On the edge after it, busy and imm_ready go high and stay high. The edge where imm_valid is sampled high writes imm_data, and busy falls on that same edge.
- R6: A word with bits 15:11 = 00001 writes register 0x18 + bits 10:8. The value written is bits 7:0 sign-extended to 16 bits.
- R7: With mode40 high, any write to 0x1E or 0x1F also clears the matching low part (0x1C or 0x1D). It sets the matching high part (0x10 or 0x11) to all copies of bit 15 of the written value.
- R8: With mode40 low, a write to 0x1E or 0x1F changes only that register.
- R9: Registers 0x10 and 0x11 store only bits 7:0 of a written value and always read as that byte sign-extended to 16 bits.
- R10: The register file does not change on an edge with any of the following: an unrecognised word, no valid word, an instruction word while busy, or an immediate word while idle.
- R11: rd_data shows register rd_sel combinationally, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | instr_word holds an instruction this cycle |
| instr_word | input | 16 | Instruction word |
| mode40 | input | 1 | 40-bit accumulator mode from the status register |
| busy | output | 1 | Waiting for the immediate word of a long load |
| imm_valid | input | 1 | imm_data holds the immediate word |
| imm_data | input | 16 | Immediate word for a long load |
| imm_ready | output | 1 | Unit accepts imm_data this cycle |
| rd_sel | input | 5 | Register read index |
| rd_data | output | 16 | Register read data |

## Verification
The bench runs random moves, short loads and long loads under a randomly toggled mode. It compares all 32 registers against a reference model after every operation. Directed cases set up accumulators just above and just below the signed 32-bit range. If the saturation decision were taken from the wrong bits or with the wrong sign, these moves would return the raw middle value or the opposite limit. Other cases write a middle part in each mode: if extension were missing, or applied in 16-bit mode, stale low or high parts would remain or be wrongly cleared. Further cases send instruction words during a long-load wait and immediate words while idle, which would corrupt registers if they were not ignored.

// File: rtl/mrm_pkg.sv
package mrm_pkg;
    localparam int DW        = 16;
    localparam int NREG      = 32;
    localparam int AW        = $clog2(NREG);
    localparam int HIW       = 8;
    localparam int NACC      = 2;
    localparam logic [AW-1:0] ACC_HI0   = 5'h10;
    localparam logic [AW-1:0] SHORT_BASE = 5'h18;
    localparam logic [AW-1:0] ACC_LO0   = 5'h1C;
    localparam logic [AW-1:0] ACC_MID0  = 5'h1E;

    typedef logic [NREG-1:0][DW-1:0] rf_t;
    typedef enum logic [1:0] {OP_NONE, OP_MOVE, OP_LOADW, OP_LOADS} op_e;
    typedef enum logic {ST_IDLE, ST_WAIT} st_e;

    typedef struct packed {
        st_e           st;
        logic [AW-1:0] pend;
        rf_t           regs;
    } state_t;
endpackage

// File: rtl/mrm_decode.sv
module mrm_decode
    import mrm_pkg::*;
(
    input  logic [DW-1:0] word,
    output op_e           op,
    output logic [AW-1:0] dst,
    output logic [AW-1:0] src,
    output logic [DW-1:0] short_val
);
    always_comb begin
        op        = OP_NONE;
        dst       = word[9:5];
        src       = word[4:0];
        short_val = {{(DW-8){word[7]}}, word[7:0]};
        if (word[15:10] == 6'b000111) begin
            op = OP_MOVE;
        end else if (word[15:5] == 11'b00000000100) begin
            op  = OP_LOADW;
            dst = word[4:0];
        end else if (word[15:11] == 5'b00001) begin
            op  = OP_LOADS;
            dst = SHORT_BASE + {2'b00, word[10:8]};
        end
    end
endmodule

// File: rtl/mrm_acc_sat.sv
module mrm_acc_sat
    import mrm_pkg::*;
(
    input  logic [DW-1:0] hi,
    input  logic [DW-1:0] mid,
    input  logic          mode40,
    output logic [DW-1:0] view
);
    logic fits;
    always_comb begin
        fits = (hi[HIW-1:0] == {HIW{mid[DW-1]}});
        if (mode40 && !fits)
            view = hi[HIW-1] ? {1'b1, {(DW-1){1'b0}}} : {1'b0, {(DW-1){1'b1}}};
        else
            view = mid;
    end
endmodule

// File: rtl/mrm_wplan.sv
module mrm_wplan
    import mrm_pkg::*;
(
    input  logic            en,
    input  logic [AW-1:0]   dst,
    input  logic [DW-1:0]   val,
    input  logic            mode40,
    output logic [NREG-1:0] wmask,
    output rf_t             wdata
);
    logic          is_hi, is_mid;
    logic [AW-1:0] lo_idx, hi_idx;

    always_comb begin
        wmask  = '0;
        wdata  = '0;
        is_hi  = (dst[AW-1:1] == ACC_HI0[AW-1:1]);
        is_mid = (dst[AW-1:1] == ACC_MID0[AW-1:1]);
        lo_idx = ACC_LO0 + {{(AW-1){1'b0}}, dst[0]};
        hi_idx = ACC_HI0 + {{(AW-1){1'b0}}, dst[0]};
        if (en) begin
            wmask[dst] = 1'b1;
            if (is_hi)
                wdata[dst] = {{(DW-HIW){val[HIW-1]}}, val[HIW-1:0]};
            else
                wdata[dst] = val;
            if (is_mid && mode40) begin
                wmask[lo_idx] = 1'b1;
                wdata[lo_idx] = '0;
                wmask[hi_idx] = 1'b1;
                wdata[hi_idx] = {DW{val[DW-1]}};
            end
        end
    end
endmodule

// File: rtl/mrm_move_load.sv
module mrm_move_load
    import mrm_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          instr_valid,
    input  logic [15:0]   instr_word,
    input  logic          mode40,
    output logic          busy,
    input  logic          imm_valid,
    input  logic [15:0]   imm_data,
    output logic          imm_ready,
    input  logic [4:0]    rd_sel,
    output logic [15:0]   rd_data
);
    state_t state_d, state_q;
    rf_t    regs_q;

    op_e             op;
    logic [AW-1:0]   dec_dst, dec_src;
    logic [DW-1:0]   short_val;
    logic [DW-1:0]   acc_view [NACC];
    logic [DW-1:0]   src_val;
    logic            wr_en;
    logic [AW-1:0]   wr_dst;
    logic [DW-1:0]   wr_val;
    logic [NREG-1:0] wmask;
    rf_t             wdata;

    assign regs_q = state_q.regs;

    mrm_decode u_dec (
        .word      (instr_word),
        .op        (op),
        .dst       (dec_dst),
        .src       (dec_src),
        .short_val (short_val)
    );

    for (genvar k = 0; k < NACC; k++) begin : g_acc
        mrm_acc_sat u_sat (
            .hi     (state_q.regs[ACC_HI0 + k]),
            .mid    (state_q.regs[ACC_MID0 + k]),
            .mode40 (mode40),
            .view   (acc_view[k])
        );
    end

    always_comb begin
        if (dec_src >= ACC_MID0)
            src_val = acc_view[dec_src[0]];
        else
            src_val = state_q.regs[dec_src];
    end

    always_comb begin
        wr_en  = 1'b0;
        wr_dst = dec_dst;
        wr_val = src_val;
        if (state_q.st == ST_WAIT) begin
            wr_en  = imm_valid;
            wr_dst = state_q.pend;
            wr_val = imm_data;
        end else if (instr_valid) begin
            wr_en  = (op == OP_MOVE) || (op == OP_LOADS);
            wr_val = (op == OP_LOADS) ? short_val : src_val;
        end
    end

    mrm_wplan u_wplan (
        .en     (wr_en),
        .dst    (wr_dst),
        .val    (wr_val),
        .mode40 (mode40),
        .wmask  (wmask),
        .wdata  (wdata)
    );

    always_comb begin
        state_d = state_q;
        for (int i = 0; i < NREG; i++) begin
            if (wmask[i]) state_d.regs[i] = wdata[i];
        end
        if (state_q.st == ST_IDLE) begin
            if (instr_valid && op == OP_LOADW) begin
                state_d.st   = ST_WAIT;
                state_d.pend = dec_dst;
            end
        end else if (imm_valid) begin
            state_d.st = ST_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '{st: ST_IDLE, pend: '0, regs: '0};
        else        state_q <= state_d;
    end

    assign busy      = (state_q.st == ST_WAIT);
    assign imm_ready = busy;
    assign rd_data   = state_q.regs[rd_sel];
endmodule

// File: rtl/mrm_chk.sv
module mrm_chk
    import mrm_pkg::*;
(
    input logic clk,
    input logic rst_n,
    input logic instr_valid,
    input logic imm_valid,
    input logic busy,
    input logic imm_ready,
    input rf_t  regs
);
    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (regs == '0 && !busy && !imm_ready));

    assert_wait_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(instr_valid));

    assert_wait_exit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && imm_valid) |=> !busy);

    assert_wait_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !imm_valid) |=> busy);

    assert_ignored_inputs_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy ? !imm_valid : !instr_valid) |=> $stable(regs));

    assert_hi_byte_width_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (regs[ACC_HI0][DW-1:HIW] == {(DW-HIW){regs[ACC_HI0][HIW-1]}}) &&
        (regs[ACC_HI0+1][DW-1:HIW] == {(DW-HIW){regs[ACC_HI0+1][HIW-1]}}));
endmodule

bind mrm_move_load mrm_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_valid (instr_valid),
    .imm_valid   (imm_valid),
    .busy        (busy),
    .imm_ready   (imm_ready),
    .regs        (regs_q)
);

// File: tb/tb_mrm_move_load.sv
module tb_mrm_move_load;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [15:0] instr_word = '0;
    logic        mode40 = 1'b0;
    logic        busy;
    logic        imm_valid = 1'b0;
    logic [15:0] imm_data = '0;
    logic        imm_ready;
    logic [4:0]  rd_sel = '0;
    logic [15:0] rd_data;

    int n_cmp = 0;
    int n_bad = 0;
    logic [15:0] m [32];

    always #(CLK_PERIOD/2) clk = ~clk;

    mrm_move_load dut (.*);

    function automatic logic [15:0] sat_view(int k);
        logic [15:0] hi, mid;
        hi = m[16+k]; mid = m[30+k];
        if (mode40 && hi[7:0] != {8{mid[15]}})
            return hi[7] ? 16'h8000 : 16'h7FFF;
        return mid;
    endfunction

    task automatic m_write(int idx, logic [15:0] v);
        if (idx == 16 || idx == 17) m[idx] = {{8{v[7]}}, v[7:0]};
        else m[idx] = v;
        if ((idx == 30 || idx == 31) && mode40) begin
            m[idx-2]  = 16'h0000;
            m[idx-14] = {16{v[15]}};
        end
    endtask

    task automatic check(string req, logic [15:0] act, logic [15:0] exp, string what);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Reads every register through the R11 read port and compares with the model.
    task automatic check_all(string req);
        for (int i = 0; i < 32; i++) begin
            @(negedge clk);
            rd_sel = 5'(i);
            #1;
            check(req, rd_data, m[i], $sformatf("reg %0h", i));
        end
    endtask

    task automatic issue(logic [15:0] w);
        @(negedge clk);
        instr_valid = 1'b1; instr_word = w;
        @(negedge clk);
        instr_valid = 1'b0; instr_word = 16'hFFFF;
    endtask

    task automatic do_move(int d, int s);
        logic [15:0] v;
        v = (s >= 30) ? sat_view(s - 30) : m[s];
        issue({6'b000111, 5'(d), 5'(s)});
        m_write(d, v);
    endtask

    task automatic do_short(int d3, logic [7:0] imm);
        issue({5'b00001, 3'(d3), imm});
        m_write(24 + d3, {{8{imm[7]}}, imm});
    endtask

    task automatic do_long(int d, logic [15:0] v, int gap, bit intrude);
        issue({11'b00000000100, 5'(d)});
        #1;
        check("R5", {15'b0, busy}, 16'd1, "busy after long load word");
        check("R5", {15'b0, imm_ready}, 16'd1, "imm_ready after long load word");
        for (int g = 0; g < gap; g++) @(negedge clk);
        if (intrude) begin
            // R10: instruction words while busy are ignored
            issue({6'b000111, 5'd0, 5'd1});
            issue({5'b00001, 3'd0, 8'h55});
        end
        @(negedge clk);
        imm_valid = 1'b1; imm_data = v;
        @(negedge clk);
        imm_valid = 1'b0; imm_data = 16'h0;
        #1;
        check("R5", {15'b0, busy}, 16'd0, "busy after immediate accepted");
        m_write(d, v);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < 32; i++) m[i] = 16'h0;
        repeat (3) @(negedge clk);
        #1;
        check("R1", {15'b0, busy}, 16'd0, "busy in reset");
        check("R1", {15'b0, imm_ready}, 16'd0, "imm_ready in reset");
        rst_n = 1'b1;
        check_all("R1");

        // R11: read port follows rd_sel without a clock edge
        do_long(3, 16'hA5A5, 0, 0);
        do_long(4, 16'h1234, 2, 0);
        @(negedge clk);
        rd_sel = 5'd3; #1;
        check("R11", rd_data, 16'hA5A5, "comb read 3");
        rd_sel = 5'd4; #1;
        check("R11", rd_data, 16'h1234, "comb read 4");

        // R2 plain move
        do_move(7, 3);
        check_all("R2");

        // R6 short loads, negative and positive, including an accumulator low part
        do_short(0, 8'h80);
        do_short(4, 8'h7F);
        check_all("R6");

        // R9 high part keeps only a byte
        do_long(16, 16'h3C81, 1, 0);
        check_all("R9");

        // R7 / R8 writes to a middle part in each mode
        mode40 = 1'b0;
        do_long(28, 16'hBEEF, 0, 0);
        do_long(30, 16'h8001, 0, 0);
        check_all("R8");
        mode40 = 1'b1;
        do_long(31, 16'h8002, 0, 0);
        do_short(6, 8'h10);
        check_all("R7");

        // R3 positive overflow: hi=0x01, mid=0x1234
        do_long(30, 16'h1234, 0, 0);
        do_long(16, 16'h0001, 0, 0);
        do_move(1, 30);
        @(negedge clk); rd_sel = 5'd1; #1;
        check("R3", rd_data, 16'h7FFF, "positive saturation");
        // R4 same accumulator with mode off gives raw middle
        mode40 = 1'b0;
        do_move(2, 30);
        @(negedge clk); rd_sel = 5'd2; #1;
        check("R4", rd_data, 16'h1234, "raw middle in 16-bit mode");
        // R3 negative overflow: hi=0xFE, mid=0x0001
        mode40 = 1'b1;
        do_long(31, 16'h0001, 0, 0);
        do_long(17, 16'h00FE, 0, 0);
        do_move(5, 31);
        @(negedge clk); rd_sel = 5'd5; #1;
        check("R3", rd_data, 16'h8000, "negative saturation");
        // R3 in range: hi=0xFF, mid=0x9000
        do_long(31, 16'h9000, 0, 0);
        do_move(6, 31);
        @(negedge clk); rd_sel = 5'd6; #1;
        check("R3", rd_data, 16'h9000, "in-range middle");
        check_all("R3");

        // R10 unrecognised words, intruding words, stray immediates
        issue(16'h8123);
        issue(16'h0004);
        @(negedge clk); imm_valid = 1'b1; imm_data = 16'hDEAD;
        @(negedge clk); imm_valid = 1'b0;
        do_long(9, 16'h0F0F, 1, 1);
        check_all("R10");

        // random mix
        for (int n = 0; n < 220; n++) begin
            int kind;
            @(negedge clk);
            mode40 = 1'($urandom_range(0, 1));
            kind = $urandom_range(0, 9);
            if (kind < 4) begin
                int s;
                s = (kind == 0) ? $urandom_range(30, 31) : $urandom_range(0, 31);
                do_move($urandom_range(0, 31), s);
                check_all((s >= 30) ? (mode40 ? "R3" : "R4") : "R2");
            end else if (kind < 6) begin
                do_short($urandom_range(0, 7), 8'($urandom));
                check_all("R6");
            end else if (kind < 9) begin
                int d;
                d = (kind == 8) ? $urandom_range(30, 31) : $urandom_range(0, 31);
                do_long(d, 16'($urandom), $urandom_range(0, 2), 1'($urandom_range(0, 1)));
                check_all(mode40 ? "R7" : "R5");
            end else begin
                issue(16'h8000 | 16'($urandom));
                check_all("R10");
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule